// File: doc/BRIEF.md
# Three-Phase Dead-Time PWM Generator

This block drives the six gate signals of a three-phase inverter bridge, one high-side and one low-side switch for each phase leg. A single up/down carrier is shared by the three phases. Each phase compares the carrier against an effective duty value. The high-side and low-side outputs of a leg are derived from that comparison, and a programmable dead time separates them, so neither switch turns on until the other has been off for that many cycles.

After reset the outputs stay low for a start-up interval so that the bootstrap supplies of the high-side drivers can charge. The bridge then runs at half duty (a zero output voltage) until the host supplies its first set of values. The host presents the period, three duty values and a reload prescaler on input buses and pulses a request that raises a ready flag. At a carrier period boundary, once the prescaler count has run out, the block captures those values and clears the flag. Three current-direction inputs are sampled at every period boundary and shift each phase's duty up or down by half the dead time, which compensates the voltage lost during the dead interval. The compensated duty is then limited by a minimum pulse width.

Top module: `inv3_pwm_dt`

## Requirements
- R1: While `rst_n` is low at a clock edge, all six outputs and `load_ready` are low after that edge.
- R2: After reset is released, all outputs stay low for STARTUP_CYCLES clock edges. The low-side outputs go high after edge number STARTUP_CYCLES, and from then on the carrier keeps running until the next reset.
- R3: The carrier counts up from 0 to P-1 and then back down to 0, holding each end value for two cycles, so one PWM period is 2·P cycles. A phase reference is high while the count is at least P minus that phase's effective duty E, which gives 2·E high cycles per period, centred on the carrier peak.
- R4: Until the first capture, the period is DEF_PERIOD and every phase duty is DEF_PERIOD/2.
- R5: Each output switches on `dead_time` cycles after its phase reference changes and switches off as soon as the reference changes. The high-side pulse therefore lasts 2·E − `dead_time` cycles and the low-side pulse lasts 2·(P − E) − `dead_time` cycles. The two outputs of a leg are never high together.
- R6: At each period boundary, phase i's effective duty is the duty plus floor(`dead_time`/2) when `cur_pos[i]` is 1, and the duty minus that amount when it is 0. The result is clamped to the range 0 to P.
- R7: An effective duty below `min_pulse` becomes 0, which holds the high side off and the low side on. An effective duty that lies within `min_pulse` of P becomes P, which holds the high side on and the low side off.
- R8: A one-cycle `load_req` raises `load_ready` after the next edge. The block clears `load_ready` on the edge at which it captures the inputs. If a capture and a request fall in the same cycle, the clear wins.
- R9: `period_in`, `duty_in` and `prescale_in` are captured only at a running period boundary where the prescaler count is zero and `load_ready` is high. At all other times, changes on those inputs have no effect on the outputs.
- R10: A capture with `prescale_in` = N (N = 0 is treated as 1) blocks the next capture for N periods. If `load_ready` is raised again at once, the two clears are exactly N·2·P cycles apart.
- R11: The `cur_pos` inputs are re-sampled at every period boundary whether or not a capture takes place, so a change in current direction alters the pulse widths without a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_req | input | 1 | One-cycle pulse from the host: new values are ready |
| period_in | input | CNT_W | Carrier half-period P in cycles (one PWM period is 2·P) |
| prescale_in | input | PSC_W | Number of PWM periods between captures |
| duty_in | input | 3×CNT_W | Per-phase duty, index 0 = phase A, 1 = B, 2 = C |
| dead_time | input | CNT_W | Dead time in cycles (static) |
| min_pulse | input | CNT_W | Minimum effective duty in cycles (static) |
| cur_pos | input | 3 | Per-phase current sign, 1 = positive, 0 = negative |
| load_ready | output | 1 | Host flag: set by a request, cleared by a capture |
| top_o | output | 3 | High-side gate outputs, one per phase |
| bot_o | output | 3 | Low-side gate outputs, one per phase |

## Verification
The assertions assume that `dead_time` and `min_pulse` stay constant while the block runs, that the period is at least 2, and that `load_req` is a single-cycle pulse. The no-overlap and dead-gap properties depend on these assumptions. The bench sets the two static values before reset is released and never changes them afterwards. It always loads periods well above twice the dead time, and it drives each request for exactly one cycle from a task. Pulse widths are measured on the third pulse after a change, so the check never sees the transitional period in which the old and new duty values meet.

// File: rtl/pwm3_pkg.sv
// Shared definitions for the three-phase dead-time PWM block.
package pwm3_pkg;
    localparam int NPH = 3;               // number of inverter phase legs

    typedef enum logic {
        CNT_UP = 1'b0,
        CNT_DN = 1'b1
    } dir_t;
endpackage

// File: rtl/pwm_carrier.sv
// Start-up delay and centre-aligned carrier.
// Holds the outputs idle for STARTUP_CYCLES edges after reset, then runs an
// up/down counter 0..period-1..0 that holds each end for two cycles.
// Assumes that period >= 2 and that period changes only while boundary is high.
module pwm_carrier
    import pwm3_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int STARTUP_CYCLES = 32000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic             boundary
);
    localparam int              SU_W    = $clog2(STARTUP_CYCLES + 1);
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

    logic [SU_W-1:0] su_cnt;
    dir_t            dir;

    // Period boundary: the last start-up cycle, or the valley of a running carrier.
    assign boundary = (!running && su_cnt == SU_LAST) ||
                      (running && dir == CNT_DN && cnt == '0);

    // Start-up timer, then the up/down carrier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            su_cnt  <= '0;
            running <= 1'b0;
            cnt     <= '0;
            dir     <= CNT_UP;
        end else if (!running) begin
            if (su_cnt == SU_LAST) running <= 1'b1;
            else                   su_cnt  <= su_cnt + 1'b1;
        end else if (dir == CNT_UP) begin
            if (cnt == period - 1'b1) dir <= CNT_DN;
            else                      cnt <= cnt + 1'b1;
        end else begin
            if (cnt == '0) dir <= CNT_UP;
            else           cnt <= cnt - 1'b1;
        end
    end

    AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);                                     // R2
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < period));                              // R3
endmodule

// File: rtl/pwm_dt_comp.sv
// Dead-time compensation and minimum-pulse limiting for one phase (combinational).
// Shifts the duty by half the dead time in the direction of the current, clamps
// the result to 0..period, then snaps narrow pulses to off and narrow gaps to on.
// Assumes that min_pulse is static.
module pwm_dt_comp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] duty,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] dead_time,
    input  logic [CNT_W-1:0] min_pulse,
    input  logic             cur_pos,
    output logic [CNT_W-1:0] eff
);
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] shifted;

    assign half = dead_time >> 1;

    // Apply the signed half-dead-time shift with saturation at 0 and at period.
    always_comb begin
        if (cur_pos) begin
            if (duty >= period || half >= period - duty) shifted = period;
            else                                          shifted = duty + half;
        end else begin
            if (duty <= half)               shifted = '0;
            else if (duty - half > period)  shifted = period;
            else                            shifted = duty - half;
        end
    end

    // Minimum pulse width: a narrow pulse is dropped, a narrow gap is filled.
    always_comb begin
        if (shifted < min_pulse)               eff = '0;
        else if (period - shifted < min_pulse) eff = period;
        else                                   eff = shifted;
    end
endmodule

// File: rtl/pwm_deadband.sv
// Complementary output pair with dead time for one phase.
// Each output switches on only after the reference has been stable for
// dead_time cycles, and switches off on the cycle after the reference changes.
// Assumes that dead_time is static while enable is high.
module pwm_deadband #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             ref_in,
    input  logic [CNT_W-1:0] dead_time,
    output logic             top_o,
    output logic             bot_o
);
    logic             ref_q;
    logic [CNT_W-1:0] dtc;

    // Track the reference and count how long it has been stable, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= 1'b0;
            dtc   <= '0;
        end else if (ref_in != ref_q) begin
            ref_q <= ref_in;
            dtc   <= '0;
        end else if (dtc < dead_time) begin
            dtc <= dtc + 1'b1;
        end
    end

    assign top_o = enable &&  ref_q && (dtc >= dead_time);
    assign bot_o = enable && !ref_q && (dtc >= dead_time);

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_o && bot_o));                                       // R5
    AST_DT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $rose(top_o)) |-> !$past(bot_o));     // R5
endmodule

// File: rtl/inv3_pwm_dt.sv
// Three-phase centre-aligned PWM with dead time, current-sign compensation,
// minimum pulse width, start-up delay and a host reload handshake.
// Assumes that dead_time and min_pulse are static, that period_in >= 2, and
// that load_req is a single-cycle pulse.
module inv3_pwm_dt
    import pwm3_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int PSC_W          = 8,
    parameter int STARTUP_CYCLES = 32000,
    parameter int DEF_PERIOD     = 1000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_req,
    input  logic [CNT_W-1:0]          period_in,
    input  logic [PSC_W-1:0]          prescale_in,
    input  logic [NPH-1:0][CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0]          dead_time,
    input  logic [CNT_W-1:0]          min_pulse,
    input  logic [NPH-1:0]            cur_pos,
    output logic                      load_ready,
    output logic [NPH-1:0]            top_o,
    output logic [NPH-1:0]            bot_o
);
    localparam logic [CNT_W-1:0] DEF_P = CNT_W'(DEF_PERIOD);
    localparam logic [CNT_W-1:0] DEF_D = CNT_W'(DEF_PERIOD / 2);

    logic                      running;
    logic                      boundary;
    logic                      run_bnd;
    logic                      capture;
    logic [CNT_W-1:0]          cnt;
    logic [CNT_W-1:0]          act_period;
    logic [CNT_W-1:0]          sel_period;
    logic [NPH-1:0][CNT_W-1:0] act_duty;
    logic [NPH-1:0][CNT_W-1:0] sel_duty;
    logic [NPH-1:0][CNT_W-1:0] eff_c;
    logic [NPH-1:0][CNT_W-1:0] eff_q;
    logic [NPH-1:0]            ref_c;
    logic [PSC_W-1:0]          psc_cnt;
    logic                      ready_q;

    pwm_carrier #(
        .CNT_W          (CNT_W),
        .STARTUP_CYCLES (STARTUP_CYCLES)
    ) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .period   (act_period),
        .running  (running),
        .cnt      (cnt),
        .boundary (boundary)
    );

    assign run_bnd    = boundary && running;
    assign capture    = run_bnd && (psc_cnt == '0) && ready_q;
    assign sel_period = capture ? period_in : act_period;
    assign sel_duty   = capture ? duty_in   : act_duty;
    assign load_ready = ready_q;

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        pwm_dt_comp #(.CNT_W(CNT_W)) u_comp (
            .duty      (sel_duty[i]),
            .period    (sel_period),
            .dead_time (dead_time),
            .min_pulse (min_pulse),
            .cur_pos   (cur_pos[i]),
            .eff       (eff_c[i])
        );

        assign ref_c[i] = running && (cnt >= act_period - eff_q[i]);

        pwm_deadband #(.CNT_W(CNT_W)) u_db (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (running),
            .ref_in    (ref_c[i]),
            .dead_time (dead_time),
            .top_o     (top_o[i]),
            .bot_o     (bot_o[i])
        );

        AST_EFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            running |-> (eff_q[i] <= act_period));                // R6
    end

    // Active values, prescaler count and the latched effective duties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= DEF_P;
            act_duty   <= {NPH{DEF_D}};
            psc_cnt    <= '0;
            eff_q      <= '0;
        end else begin
            if (capture) begin
                act_period <= period_in;
                act_duty   <= duty_in;
                psc_cnt    <= (prescale_in == '0) ? '0 : prescale_in - 1'b1;
            end else if (run_bnd && psc_cnt != '0) begin
                psc_cnt <= psc_cnt - 1'b1;
            end
            if (boundary) eff_q <= eff_c;
        end
    end

    // Host flag: a request sets it, a capture clears it (the clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n)        ready_q <= 1'b0;
        else if (capture)  ready_q <= 1'b0;
        else if (load_req) ready_q <= 1'b1;
    end

    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> !load_ready);                                 // R8
    AST_PSC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_cnt != '0 && load_ready) |=> load_ready);            // R10
endmodule

// File: tb/tb_inv3_pwm_dt.sv
module tb_inv3_pwm_dt;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 12;
    localparam int SU  = 200;
    localparam int DP  = 100;
    localparam int DT  = 4;
    localparam int MPW = 6;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                load_req = 1'b0;
    logic [CW-1:0]       period_in = '0;
    logic [7:0]          prescale_in = '0;
    logic [2:0][CW-1:0]  duty_in = '0;
    logic [CW-1:0]       dead_time = CW'(DT);
    logic [CW-1:0]       min_pulse = CW'(MPW);
    logic [2:0]          cur_pos = 3'b101;
    logic                load_ready;
    logic [2:0]          top_o;
    logic [2:0]          bot_o;

    int errors = 0;
    int checks = 0;
    int overlap_err = 0;

    inv3_pwm_dt #(
        .CNT_W(CW), .PSC_W(8), .STARTUP_CYCLES(SU), .DEF_PERIOD(DP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .load_req(load_req), .period_in(period_in),
        .prescale_in(prescale_in), .duty_in(duty_in), .dead_time(dead_time),
        .min_pulse(min_pulse), .cur_pos(cur_pos), .load_ready(load_ready),
        .top_o(top_o), .bot_o(bot_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Shoot-through monitor, reported as one check at the end.
    always @(negedge clk) if (rst_n && (top_o & bot_o) != 3'b000) overlap_err++;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int ph, input bit is_top);
        return is_top ? top_o[ph] : bot_o[ph];
    endfunction

    // Width of the third complete pulse on one output.
    task automatic measure_width(input int ph, input bit is_top, output int w);
        int guard = 0;
        w = 0;
        for (int k = 0; k < 3; k++) begin
            while (sig(ph, is_top) == 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
            while (sig(ph, is_top) == 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
            w = 0;
            while (sig(ph, is_top) == 1'b1 && guard < 4000) begin w++; @(negedge clk); guard++; end
        end
    endtask

    // Cycles from one rising high-side edge to the next.
    task automatic measure_period(input int ph, output int p);
        int w;
        measure_width(ph, 1'b1, w);
        p = w;
        while (top_o[ph] == 1'b0 && p < 4000) begin p++; @(negedge clk); end
    endtask

    // Both outputs of a leg must hold constant levels for n cycles.
    task automatic hold_check(input string req, input int ph, input bit et, input bit eb, input int n);
        int bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (top_o[ph] != et || bot_o[ph] != eb) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic do_reload(input int p, input int d0, input int d1, input int d2, input int psc);
        int guard = 0;
        @(negedge clk);
        period_in   = CW'(p);
        duty_in[0]  = CW'(d0);
        duty_in[1]  = CW'(d1);
        duty_in[2]  = CW'(d2);
        prescale_in = 8'(psc);
        load_req    = 1'b1;
        @(negedge clk);
        load_req = 1'b0;
        check("R8 flag raised by request", int'(load_ready), 1);
        while (load_ready && guard < 5000) begin @(negedge clk); guard++; end
        check("R8 flag cleared by capture", int'(load_ready), 0);
    endtask

    task automatic t_reset_startup();
        int n = 0;
        int top_seen = 0;
        repeat (5) @(negedge clk);
        check("R1 top after reset", int'(top_o), 0);
        check("R1 bottom after reset", int'(bot_o), 0);
        check("R1 flag after reset", int'(load_ready), 0);
        rst_n = 1'b1;
        while (n < 1000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (top_o != 3'b000) top_seen++;
            if (bot_o != 3'b000) break;
        end
        check("R2 start-up length", n, SU);
        check("R2 high side idle during start-up", top_seen, 0);
        check("R2 all low sides on after start-up", int'(bot_o), 7);
    endtask

    task automatic t_default();
        int w;
        measure_period(0, w);
        check("R3 R4 default period 2P", w, 2 * DP);
        measure_width(0, 1'b1, w);
        check("R4 R6 top A, E=52", w, 2 * 52 - DT);
        measure_width(1, 1'b1, w);
        check("R4 R6 top B, E=48", w, 2 * 48 - DT);
        measure_width(0, 1'b0, w);
        check("R5 bottom A", w, 2 * (DP - 52) - DT);
        measure_width(1, 1'b0, w);
        check("R5 bottom B", w, 2 * (DP - 48) - DT);
    endtask

    task automatic t_reload();
        int w;
        do_reload(80, 30, 60, 3, 1);
        measure_period(0, w);
        check("R3 R9 reloaded period", w, 160);
        measure_width(0, 1'b1, w);
        check("R9 top A, E=32", w, 2 * 32 - DT);
        measure_width(1, 1'b1, w);
        check("R9 top B, E=58", w, 2 * 58 - DT);
        measure_width(1, 1'b0, w);
        check("R5 bottom B", w, 2 * (80 - 58) - DT);
        hold_check("R7 narrow pulse dropped on C", 2, 1'b0, 1'b1, 320);
    endtask

    task automatic t_ignore();
        int w;
        @(negedge clk);
        period_in  = CW'(50);
        duty_in[0] = CW'(10);
        measure_width(0, 1'b1, w);
        check("R9 inputs ignored without request", w, 2 * 32 - DT);
        check("R9 flag stays low", int'(load_ready), 0);
    endtask

    task automatic t_sign();
        int w;
        @(negedge clk);
        cur_pos[0] = 1'b0;
        measure_width(0, 1'b1, w);
        check("R11 sign flip without reload, E=28", w, 2 * 28 - DT);
        cur_pos[0] = 1'b1;
        measure_width(0, 1'b1, w);
        check("R11 sign restored, E=32", w, 2 * 32 - DT);
    endtask

    task automatic t_clamp_gap();
        do_reload(80, 30, 1, 76, 1);
        repeat (320) @(negedge clk);
        hold_check("R6 low clamp on B", 1, 1'b0, 1'b1, 320);
        hold_check("R7 narrow gap filled on C", 2, 1'b1, 1'b0, 320);
        do_reload(80, 30, 60, 79, 1);
        repeat (320) @(negedge clk);
        hold_check("R6 high clamp on C", 2, 1'b1, 1'b0, 320);
    endtask

    task automatic t_prescale();
        int n = 0;
        do_reload(80, 30, 60, 3, 3);
        load_req = 1'b1;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            load_req = 1'b0;
            if (!load_ready && n > 1) break;
        end
        check("R10 prescaled interval", n, 3 * 160);
    endtask

    initial begin
        t_reset_startup();
        t_default();
        t_reload();
        t_ignore();
        t_sign();
        t_clamp_gap();
        t_prescale();
        check("R5 no overlap of a pair", overlap_err, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule